// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block models the command front end of a x16 parallel NOR flash. It samples the chip-enable, write-enable and output-enable strobes (all active low) together with the address and data buses on a system clock. It recognises the unlock-protected command sequences for word program, sector erase, block erase and chip erase, and it applies each one to a small on-chip word array. The internal operation is simulated and lasts a parameterised number of clock cycles.

While an internal operation runs, the block ignores further writes. During that time reads do not return array data. They return a status word whose top status bit is the inverse of the word being written, and whose next bit flips on every new read. The array powers up erased (all ones). Programming can only clear bits. Erasing returns words to all ones.

Top module: `nor_cmd_decoder`

## Requirements
- R1: A write cycle spans the time both ceN and weN are low. The address is taken on the clock where that condition first holds, and the data on the clock where it first stops holding.
- R2: dataOe is 1 exactly when ceN and oeN are both low, and 0 otherwise.
- R3: After reset every array word reads 16'hFFFF. When no operation runs, a read returns the word indexed by the low ARRAY_AW address bits, so addresses alias modulo the array size.
- R4: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by a write of data D at address A, program word A. The command byte is compared on data bits [7:0].
- R5: A program sets the target word to its old value AND D, so no bit ever goes from 0 to 1.
- R6: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by 30h at address A, set to all ones every word that shares A's sector. A sector is a group of 2^SECTOR_AW words aligned on that size. No other word changes.
- R7: The same five-write prefix followed by 50h at address A sets to all ones every word in A's aligned block of 2^BLOCK_AW words. No other word changes.
- R8: The same prefix followed by 10h written at 5555h sets the whole array to ones. The byte 10h at any other address starts nothing.
- R9: After the final write of a sequence ends, the status word is returned for PROG_CYCLES (program) or ERASE_CYCLES (erase) clock cycles. The cycle after that, reads return the updated array.
- R10: During an operation the status word has bit 7 equal to the inverse of bit 7 of the program data (0 for erase), bit 6 starting at 1 on the first read and flipping on each new read, and all other bits 0.
- R11: Writes made during an operation are ignored and leave the array unchanged.
- R12: A write that does not match the next expected step returns the decoder to idle without changing the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address bus |
| dataIn | input | DATA_W | Write data bus |
| dataOut | output | DATA_W | Read data or status word |
| dataOe | output | 1 | Read data valid / output driver enable |

## Verification
The bench builds the block with a 256-word array, 16-word sectors and 64-word blocks. This lets one sector erase, one block erase and the word aliasing above the array size all be observed with a few reads. It shortens the operations to 8 program cycles and 20 erase cycles. The exact last status cycle can then be sampled, and a whole four-write program sequence fits inside an erase and can be shown to be ignored.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } opKind_e;

  typedef struct packed {
    logic    start;
    logic    finish;
    logic    busy;
    opKind_e kind;
  } ctrlStrb_t;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_WORD  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_BLK   = 8'h50;

endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA,
  parameter int PROG_CYCLES = 16,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnd,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdByte,
  output ctrlStrb_t         strb
);

  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_KEY1, S_KEY2, S_WORD, S_ERA1, S_ERA2, S_ERA3, S_BUSY
  } seqState_e;

  seqState_e state, stateNext;
  opKind_e   kindReg, kindNow;
  logic      startNow, finishNow;
  logic [CNT_W-1:0] cnt;
  logic hitA, hitB;

  assign hitA = (cmdAddr == KEY_ADDR_A);
  assign hitB = (cmdAddr == KEY_ADDR_B);

  always_comb begin
    stateNext = state;
    startNow  = 1'b0;
    kindNow   = kindReg;
    finishNow = (state == S_BUSY) && (cnt == '0);
    if (finishNow) begin
      stateNext = S_IDLE;
    end else if (wrEnd) begin
      case (state)
        S_IDLE: stateNext = (hitA && cmdByte == CMD_KEY1) ? S_KEY1 : S_IDLE;
        S_KEY1: stateNext = (hitB && cmdByte == CMD_KEY2) ? S_KEY2 : S_IDLE;
        S_KEY2: begin
          if (hitA && cmdByte == CMD_WORD)       stateNext = S_WORD;
          else if (hitA && cmdByte == CMD_ERASE) stateNext = S_ERA1;
          else                                   stateNext = S_IDLE;
        end
        S_WORD: begin
          startNow  = 1'b1;
          kindNow   = OP_PROG;
          stateNext = S_BUSY;
        end
        S_ERA1: stateNext = (hitA && cmdByte == CMD_KEY1) ? S_ERA2 : S_IDLE;
        S_ERA2: stateNext = (hitB && cmdByte == CMD_KEY2) ? S_ERA3 : S_IDLE;
        S_ERA3: begin
          stateNext = S_IDLE;
          if (hitA && cmdByte == CMD_CHIP) begin
            startNow = 1'b1; kindNow = OP_CHIP; stateNext = S_BUSY;
          end else if (cmdByte == CMD_SECT) begin
            startNow = 1'b1; kindNow = OP_SECT; stateNext = S_BUSY;
          end else if (cmdByte == CMD_BLK) begin
            startNow = 1'b1; kindNow = OP_BLK; stateNext = S_BUSY;
          end
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kindReg <= OP_PROG;
      cnt     <= '0;
    end else begin
      state <= stateNext;
      if (startNow) begin
        kindReg <= kindNow;
        cnt     <= (kindNow == OP_PROG) ? PROG_LOAD : ERASE_LOAD;
      end else if (state == S_BUSY && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign strb.start  = startNow;
  assign strb.finish = finishNow;
  assign strb.busy   = (state == S_BUSY);
  assign strb.kind   = startNow ? kindNow : kindReg;

  // R9: a started operation is busy on the next cycle
  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> strb.busy);

  // R9: leaving busy happens only through the finish strobe
  assert_busy_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.busy) |-> $past(strb.finish));

  // R9: the duration counter never exceeds the longest load value
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_CYC - 1));

  // R11: the operation kind is held for the whole busy window
  assert_kind_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && $past(strb.busy)) |-> $stable(kindReg));

endmodule

// File: rtl/nor_cmd_dp.sv
module nor_cmd_dp
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int ARRAY_AW = 8,
  parameter int SECTOR_AW = 4,
  parameter int BLOCK_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrb_t         strb,
  output logic              wrEnd,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdByte,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int WORDS = 1 << ARRAY_AW;

  logic wrNow, wrPrev, wrStart, rdNow, rdPrev, rdStart;
  logic [ADDR_W-1:0]   addrLat;
  logic [ARRAY_AW-1:0] opIdx;
  logic [DATA_W-1:0]   opData;
  logic                toggleBit;
  logic [DATA_W-1:0]   mem [WORDS];
  logic [WORDS-1:0]    sectHit, blkHit;
  logic [DATA_W-1:0]   statusWord;

  assign wrNow   = !ceN && !weN;
  assign rdNow   = !ceN && !oeN;
  assign wrStart = wrNow && !wrPrev;
  assign wrEnd   = !wrNow && wrPrev;
  assign rdStart = rdNow && !rdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b0;
      rdPrev  <= 1'b0;
      addrLat <= '0;
    end else begin
      wrPrev <= wrNow;
      rdPrev <= rdNow;
      if (wrStart) addrLat <= addr;
    end
  end

  assign cmdAddr = addrLat;
  assign cmdByte = dataIn[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opIdx     <= '0;
      opData    <= '1;
      toggleBit <= 1'b0;
    end else if (strb.start) begin
      opIdx     <= addrLat[ARRAY_AW-1:0];
      opData    <= (strb.kind == OP_PROG) ? dataIn : '1;
      toggleBit <= 1'b0;
    end else if (strb.busy && rdStart) begin
      toggleBit <= ~toggleBit;
    end
  end

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_hit
    localparam logic [ARRAY_AW-1:0] IDX = ARRAY_AW'(gi);
    assign sectHit[gi] = (IDX[ARRAY_AW-1:SECTOR_AW] == opIdx[ARRAY_AW-1:SECTOR_AW]);
    assign blkHit[gi]  = (IDX[ARRAY_AW-1:BLOCK_AW] == opIdx[ARRAY_AW-1:BLOCK_AW]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (strb.finish) begin
      for (int i = 0; i < WORDS; i++) begin
        case (strb.kind)
          OP_PROG: if (opIdx == ARRAY_AW'(i)) mem[i] <= mem[i] & opData;
          OP_SECT: if (sectHit[i]) mem[i] <= '1;
          OP_BLK:  if (blkHit[i]) mem[i] <= '1;
          default: mem[i] <= '1;
        endcase
      end
    end
  end

  always_comb begin
    statusWord    = '0;
    statusWord[7] = ~opData[7];
    statusWord[6] = toggleBit;
  end

  assign dataOe  = rdNow;
  assign dataOut = strb.busy ? statusWord : mem[addr[ARRAY_AW-1:0]];

  // R5: a program finish never turns a 0 bit into a 1
  assert_prog_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && strb.kind == OP_PROG) |=> ((mem[opIdx] & ~$past(mem[opIdx])) == '0));

  // R8: chip erase leaves both ends of the array at all ones
  assert_chip_ones_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && strb.kind == OP_CHIP) |=> (mem[0] == '1 && mem[WORDS-1] == '1));

  // R11: the target word stays frozen while the operation is still pending
  assert_array_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.finish) |=> (mem[opIdx] == $past(mem[opIdx])));

  // R10: each new read during an operation flips the toggle bit
  assert_toggle_flip_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && rdStart) |=> (toggleBit != $past(toggleBit)));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int ARRAY_AW = 8,
  parameter int SECTOR_AW = 4,
  parameter int BLOCK_AW = 6,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA,
  parameter int PROG_CYCLES = 16,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  ctrlStrb_t         strb;
  logic              wrEnd;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdByte;

  nor_cmd_ctrl #(
    .ADDR_W(ADDR_W), .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEnd(wrEnd), .cmdAddr(cmdAddr),
    .cmdByte(cmdByte), .strb(strb)
  );

  nor_cmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_AW(ARRAY_AW),
    .SECTOR_AW(SECTOR_AW), .BLOCK_AW(BLOCK_AW)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .strb(strb), .wrEnd(wrEnd),
    .cmdAddr(cmdAddr), .cmdByte(cmdByte), .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;

  localparam int PROG_C = 8;
  localparam int ERASE_C = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [15:0] addr = '0, dataIn = '0;
  logic [15:0] dataOut;
  logic dataOe;
  int total = 0, bad = 0;
  logic [15:0] rv;
  logic rOe;

  always #4 clk = ~clk;

  nor_cmd_decoder #(
    .ARRAY_AW(8), .SECTOR_AW(4), .BLOCK_AW(6),
    .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C)
  ) i_nor_cmd_decoder (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  // {address, program data, expected word afterwards}
  localparam logic [47:0] VEC [8] = '{
    {16'h0010, 16'h1234, 16'h1234},
    {16'h0010, 16'hFF00, 16'h1200},
    {16'h0011, 16'hA5A5, 16'hA5A5},
    {16'h00FF, 16'h0F0F, 16'h0F0F},
    {16'h0100, 16'h7777, 16'h7777},
    {16'h0000, 16'hFFFF, 16'h7777},
    {16'h0020, 16'h8001, 16'h8001},
    {16'h0020, 16'h0001, 16'h0001}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); weN = 1'b1; ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v, output logic oe);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); v = dataOut; oe = dataOe;
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase(input logic [15:0] a, input logic [15:0] cmd);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(a, cmd);
  endtask

  task automatic settle();
    repeat (ERASE_C + 4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 reset state and R2 output enable
    rd(16'h0033, rv, rOe);
    chk("R3 reset word", rv, 16'hFFFF);
    chk("R2 oe on read", {15'd0, rOe}, 16'd1);
    ceN = 1'b0; oeN = 1'b1; #1;
    chk("R2 oe off oeN high", {15'd0, dataOe}, 16'd0);
    ceN = 1'b1; oeN = 1'b0; #1;
    chk("R2 oe off ceN high", {15'd0, dataOe}, 16'd0);
    oeN = 1'b1;
    @(negedge clk);

    // R4 R5 R10 R3: table of programs
    for (int k = 0; k < 8; k++) begin
      logic [15:0] va, vd, ve;
      {va, vd, ve} = VEC[k];
      prog(va, vd);
      rd(va, rv, rOe);
      chk("R10 program status", rv, {8'h00, ~vd[7], 1'b1, 6'd0});
      settle();
      rd(va, rv, rOe);
      chk("R4 R5 programmed word", rv, ve);
    end

    // R1: address taken at write start, data at write end
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    @(negedge clk); addr = 16'h0040; dataIn = 16'h00FF; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); addr = 16'h0041; dataIn = 16'h3C3C;
    @(negedge clk); weN = 1'b1; ceN = 1'b1;
    @(negedge clk);
    settle();
    rd(16'h0040, rv, rOe); chk("R1 address at start", rv, 16'h3C3C);
    rd(16'h0041, rv, rOe); chk("R1 other word untouched", rv, 16'hFFFF);

    // R9: exact length of the program status window
    prog(16'h0050, 16'h0000);
    addr = 16'h0050; ceN = 1'b0; oeN = 1'b0;
    begin
      logic allStatus;
      allStatus = 1'b1;
      for (int k = 1; k < PROG_C; k++) begin
        @(negedge clk);
        if (dataOut !== 16'h00C0) allStatus = 1'b0;
      end
      chk("R9 status for whole window", {15'd0, allStatus}, 16'd1);
      @(negedge clk);
      chk("R9 array right after window", dataOut, 16'h0000);
    end
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);

    // R6 R10: sector erase with toggling status
    erase(16'h0015, 16'h0030);
    rd(16'h0015, rv, rOe); chk("R10 erase read 1", rv, 16'h0040);
    rd(16'h0015, rv, rOe); chk("R10 erase read 2", rv, 16'h0000);
    rd(16'h0015, rv, rOe); chk("R10 erase read 3", rv, 16'h0040);
    settle();
    rd(16'h0010, rv, rOe); chk("R6 sector word erased", rv, 16'hFFFF);
    rd(16'h0011, rv, rOe); chk("R6 sector word erased b", rv, 16'hFFFF);
    rd(16'h0020, rv, rOe); chk("R6 next sector kept", rv, 16'h0001);
    rd(16'h0000, rv, rOe); chk("R6 lower sector kept", rv, 16'h7777);

    // R12: broken sequences do nothing
    wr(16'h5555, 16'h00AA); wr(16'h2AAB, 16'h0055); wr(16'h5555, 16'h00A0);
    wr(16'h0060, 16'h0000);
    settle();
    rd(16'h0060, rv, rOe); chk("R12 broken program ignored", rv, 16'hFFFF);
    erase(16'h0005, 16'h0020);
    settle();
    rd(16'h0000, rv, rOe); chk("R12 bad erase command ignored", rv, 16'h7777);
    prog(16'h0060, 16'h1111);
    settle();
    rd(16'h0060, rv, rOe); chk("R12 recovers to idle", rv, 16'h1111);

    // R7 R11: block erase, with a program attempted while busy
    erase(16'h0005, 16'h0050);
    prog(16'h00FF, 16'h0000);
    settle();
    rd(16'h0000, rv, rOe); chk("R7 block word erased", rv, 16'hFFFF);
    rd(16'h0020, rv, rOe); chk("R7 block word erased b", rv, 16'hFFFF);
    rd(16'h0040, rv, rOe); chk("R7 next block kept", rv, 16'h3C3C);
    rd(16'h00FF, rv, rOe); chk("R11 busy write ignored", rv, 16'h0F0F);

    // R8: chip erase only with 10h at 5555h
    erase(16'h1234, 16'h0010);
    settle();
    rd(16'h0060, rv, rOe); chk("R8 wrong chip address ignored", rv, 16'h1111);
    erase(16'h5555, 16'h0010);
    settle();
    rd(16'h0060, rv, rOe); chk("R8 chip erase word a", rv, 16'hFFFF);
    rd(16'h0040, rv, rOe); chk("R8 chip erase word b", rv, 16'hFFFF);
    rd(16'h00FF, rv, rOe); chk("R8 chip erase word c", rv, 16'hFFFF);

    finishRun();
  end

endmodule